// File: doc/BRIEF.md
# Flash Program/Erase Sequencer with Key-Guarded Start

This block sits between a bus register interface and a non-volatile memory array. Software loads a target address, a data word and an operation code. It then sets a write-enable bit, writes a three-word key sequence, and finally sets a start bit. Only then does the block issue a single-cycle program or erase strobe to the array. It stays busy until the array signals completion, or until a low-voltage condition aborts the operation.

Every register can be written in three ways: a plain write, a write that ORs bits in, and a write that clears the bits given. Reads are combinational.

Two state machines do the work. The unlock tracker has the states `U_IDLE`, `U_GOT0`, `U_GOT1` and `U_ARMED`:
- `U_IDLE` → `U_GOT0` on a key write of zero. A zero key write also goes to `U_GOT0` from any state.
- `U_GOT0` → `U_GOT1` on the first key word.
- `U_GOT1` → `U_ARMED` on the second key word.
- Any other key write, write enable being low, or a start request returns it to `U_IDLE`.

The operation sequencer has the states `S_IDLE`, `S_LAUNCH` and `S_AWAIT`:
- `S_IDLE` → `S_LAUNCH` when a start is accepted.
- `S_LAUNCH` → `S_AWAIT` for program or erase. For any other code it goes back to `S_IDLE`.
- `S_AWAIT` → `S_IDLE` on array done or on low voltage.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset the control, key, address and data registers read 0, busy is 0, and both array strobes are low.
- R2: The register select is `wr_reg`: 0 control, 1 key, 2 address, 3 data. The write mode is `wr_alias`: 0 plain write, 1 OR-in, 2 clear-bits, 3 no effect. The address register keeps ADDR_W bits and reads zero above them. The key register always reads 0.
- R3: The control register layout is: bit 15 busy (start), bit 14 write enable, bit 13 write error, bit 12 low-voltage error, bits 3:0 operation code. A start request is a control write whose resulting bit 15 is 1. It is accepted when the tracker is armed and the resulting bit 14 is 1. In that case busy reads 1 from the next cycle, and the strobe is driven in that same cycle.
- R4: A start request that is not accepted leaves busy at 0 and issues no strobe. It sets the write-error flag.
- R5: Arming requires key writes of 0x00000000, 0xAA996655 and 0x556699AA, in that order, while write enable is already 1. A wrong key value disarms the tracker, clearing write enable disarms it, and any start request disarms it.
- R6: Operation code 1 gives a one-cycle `arr_prog` pulse and code 4 gives a one-cycle `arr_erase` pulse. Any other code, including 0, gives no strobe and one cycle of busy.
- R7: During a program or erase, busy holds until `arr_done` is sampled high, and it reads 0 on the next cycle.
- R8: While busy, writes to the control, address and data registers have no effect, and `arr_addr` and `arr_wdata` hold still.
- R9: `low_volt` sampled high while waiting on the array ends the operation and sets the low-voltage flag. This takes priority over `arr_done` in the same cycle.
- R10: An accepted start clears both error flags, so a no-op start recovers from an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_reg | input | 2 | Register select for writes |
| wr_alias | input | 2 | Write mode: plain, OR-in, clear, none |
| wr_data | input | 32 | Write data |
| rd_reg | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data |
| arr_addr | output | ADDR_W | Target address to the array |
| arr_wdata | output | 32 | Word to program |
| arr_prog | output | 1 | One-cycle program strobe |
| arr_erase | output | 1 | One-cycle page-erase strobe |
| arr_done | input | 1 | Array finished the operation |
| low_volt | input | 1 | Supply too low |

## Verification
The bench builds the block with ADDR_W = 12. At that width an all-ones address write shows the truncation at bit 12, and the random addresses cover the whole register. Random rounds mix correct unlocks, single-bit-corrupted keys, keys written before write enable, and several operation codes. They also vary the array latency from zero to five cycles and pick either completion or a low-voltage abort at random.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_KEY  = 2'd1;
    localparam logic [1:0] REG_ADDR = 2'd2;
    localparam logic [1:0] REG_DATA = 2'd3;

    localparam logic [1:0] AL_DIRECT = 2'd0;
    localparam logic [1:0] AL_SET    = 2'd1;
    localparam logic [1:0] AL_CLEAR  = 2'd2;
    localparam logic [1:0] AL_NONE   = 2'd3;

    localparam logic [31:0] KEY_STEP0 = 32'h0000_0000;
    localparam logic [31:0] KEY_STEP1 = 32'hAA99_6655;
    localparam logic [31:0] KEY_STEP2 = 32'h5566_99AA;

    localparam logic [3:0] OP_NOP   = 4'd0;
    localparam logic [3:0] OP_PROG  = 4'd1;
    localparam logic [3:0] OP_ERASE = 4'd4;

    localparam int BIT_BUSY = 15;
    localparam int BIT_WREN = 14;
    localparam int BIT_WERR = 13;
    localparam int BIT_LVD  = 12;

    typedef enum logic [1:0] {U_IDLE, U_GOT0, U_GOT1, U_ARMED} unlock_st_e;
    typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_AWAIT} seq_st_e;

    function automatic logic [31:0] fold(input logic [1:0] al,
                                         input logic [31:0] cur,
                                         input logic [31:0] wd);
        logic [31:0] r;
        unique case (al)
            AL_DIRECT: r = wd;
            AL_SET:    r = cur | wd;
            AL_CLEAR:  r = cur & ~wd;
            default:   r = cur;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
    import nvm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_we,
    input  logic [31:0] key_val,
    input  logic        wren,
    input  logic        start_req,
    output logic        armed
);
    unlock_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= U_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!wren || start_req) begin
            state_d = U_IDLE;
        end else if (key_we) begin
            if (key_val == KEY_STEP0) begin
                state_d = U_GOT0;
            end else begin
                unique case (state_q)
                    U_GOT0:  state_d = (key_val == KEY_STEP1) ? U_GOT1  : U_IDLE;
                    U_GOT1:  state_d = (key_val == KEY_STEP2) ? U_ARMED : U_IDLE;
                    default: state_d = U_IDLE;
                endcase
            end
        end
    end

    always_comb armed = (state_q == U_ARMED);
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic [3:0] op,
    input  logic       arr_done,
    input  logic       low_volt,
    output logic       busy,
    output logic       waiting,
    output logic       prog_stb,
    output logic       erase_stb,
    output logic       lvd_abort
);
    seq_st_e state_q, state_d;
    logic    real_op;

    always_comb real_op = (op == OP_PROG) || (op == OP_ERASE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (launch) state_d = S_LAUNCH;
            S_LAUNCH: state_d = real_op ? S_AWAIT : S_IDLE;
            S_AWAIT:  if (low_volt || arr_done) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q != S_IDLE);
        waiting   = (state_q == S_AWAIT);
        prog_stb  = (state_q == S_LAUNCH) && (op == OP_PROG);
        erase_stb = (state_q == S_LAUNCH) && (op == OP_ERASE);
        lvd_abort = (state_q == S_AWAIT) && low_volt;
    end
endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_reg,
    input  logic [1:0]        wr_alias,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_reg,
    output logic [31:0]       rd_data,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [31:0]       arr_wdata,
    output logic              arr_prog,
    output logic              arr_erase,
    input  logic              arr_done,
    input  logic              low_volt
);
    localparam int PAD_W = 32 - ADDR_W;

    logic [3:0]        op_q;
    logic              wren_q, werr_q, lvd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       data_q;
    logic [31:0]       ctrl_view, ctrl_cand, key_val;
    logic              wr_live, ctrl_wr, start_req, launch, key_we;
    logic              busy, waiting, armed, lvd_abort;

    always_comb begin
        ctrl_view = '0;
        ctrl_view[BIT_BUSY] = busy;
        ctrl_view[BIT_WREN] = wren_q;
        ctrl_view[BIT_WERR] = werr_q;
        ctrl_view[BIT_LVD]  = lvd_q;
        ctrl_view[3:0]      = op_q;
        ctrl_cand = fold(wr_alias, ctrl_view, wr_data);
        key_val   = fold(wr_alias, 32'h0, wr_data);
        wr_live   = wr_en && (wr_alias != AL_NONE);
        ctrl_wr   = wr_live && (wr_reg == REG_CTRL) && !busy;
        key_we    = wr_live && (wr_reg == REG_KEY);
        start_req = ctrl_wr && ctrl_cand[BIT_BUSY];
        launch    = start_req && armed && ctrl_cand[BIT_WREN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_NOP;
            wren_q <= 1'b0;
            werr_q <= 1'b0;
            lvd_q  <= 1'b0;
        end else if (ctrl_wr) begin
            op_q   <= ctrl_cand[3:0];
            wren_q <= ctrl_cand[BIT_WREN];
            werr_q <= launch ? 1'b0 : (start_req ? 1'b1 : ctrl_cand[BIT_WERR]);
            lvd_q  <= launch ? 1'b0 : ctrl_cand[BIT_LVD];
        end else if (lvd_abort) begin
            lvd_q  <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (wr_live && !busy) begin
            if (wr_reg == REG_ADDR)
                addr_q <= ADDR_W'(fold(wr_alias, {{PAD_W{1'b0}}, addr_q}, wr_data));
            if (wr_reg == REG_DATA)
                data_q <= fold(wr_alias, data_q, wr_data);
        end
    end

    nvm_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_we    (key_we),
        .key_val   (key_val),
        .wren      (wren_q),
        .start_req (start_req),
        .armed     (armed)
    );

    nvm_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .op        (op_q),
        .arr_done  (arr_done),
        .low_volt  (low_volt),
        .busy      (busy),
        .waiting   (waiting),
        .prog_stb  (arr_prog),
        .erase_stb (arr_erase),
        .lvd_abort (lvd_abort)
    );

    always_comb begin
        unique case (rd_reg)
            REG_CTRL: rd_data = ctrl_view;
            REG_ADDR: rd_data = {{PAD_W{1'b0}}, addr_q};
            REG_DATA: rd_data = data_q;
            default:  rd_data = 32'h0;
        endcase
        arr_addr  = addr_q;
        arr_wdata = data_q;
    end
endmodule

// File: rtl/nvm_prog_ctrl_chk.sv
module nvm_prog_ctrl_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              armed,
    input logic              waiting,
    input logic              werr,
    input logic              lvd,
    input logic              arr_prog,
    input logic              arr_erase,
    input logic              arr_done,
    input logic              low_volt,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [31:0]       arr_wdata,
    input logic              wr_en,
    input logic [1:0]        wr_reg,
    input logic [1:0]        wr_alias,
    input logic              wr_start_bit
);
    AST_LAUNCH_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed)); // R3

    AST_REJECT_SETS_WERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg == 2'd0 && (wr_alias == 2'd0 || wr_alias == 2'd1)
         && wr_start_bit && !busy && !armed) |=> (werr && !busy)); // R4

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_prog || arr_erase) |=> (!arr_prog && !arr_erase && busy)); // R6

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && (arr_done || low_volt)) |=> !busy); // R7

    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(arr_addr) && $stable(arr_wdata))); // R8

    AST_LVD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && low_volt) |=> lvd); // R9
endmodule

bind nvm_prog_ctrl nvm_prog_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .armed        (armed),
    .waiting      (waiting),
    .werr         (werr_q),
    .lvd          (lvd_q),
    .arr_prog     (arr_prog),
    .arr_erase    (arr_erase),
    .arr_done     (arr_done),
    .low_volt     (low_volt),
    .arr_addr     (arr_addr),
    .arr_wdata    (arr_wdata),
    .wr_en        (wr_en),
    .wr_reg       (wr_reg),
    .wr_alias     (wr_alias),
    .wr_start_bit (wr_data[15])
);

// File: tb/test_nvm_prog_ctrl.sv
module test_nvm_prog_ctrl;
    import nvm_pkg::*;
    localparam int AW = 12;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_reg = '0, wr_alias = '0, rd_reg = '0;
    logic [31:0]   wr_data = '0, rd_data, arr_wdata;
    logic [AW-1:0] arr_addr;
    logic          arr_prog, arr_erase;
    logic          arr_done = 1'b0, low_volt = 1'b0;
    int            n_chk = 0, n_bad = 0, n_strobe = 0;

    always #10 clk = ~clk;

    nvm_prog_ctrl #(.ADDR_W(AW)) i_nvm_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_alias(wr_alias),
        .wr_data(wr_data), .rd_reg(rd_reg), .rd_data(rd_data), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_prog(arr_prog), .arr_erase(arr_erase),
        .arr_done(arr_done), .low_volt(low_volt)
    );

    initial forever begin
        @(negedge clk);
        if (arr_prog || arr_erase) n_strobe++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] r, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_reg = r; wr_alias = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] r, output logic [31:0] v);
        rd_reg = r;
        #1;
        v = rd_data;
    endtask

    function automatic logic [31:0] cv(input logic b, input logic we, input logic er,
                                       input logic lv, input logic [3:0] op);
        return {16'h0, b, we, er, lv, 8'h0, op};
    endfunction

    task automatic unlock();
        wr(REG_KEY, AL_DIRECT, KEY_STEP0);
        wr(REG_KEY, AL_DIRECT, KEY_STEP1);
        wr(REG_KEY, AL_DIRECT, KEY_STEP2);
    endtask

    task automatic finish_op(input int dly, input logic lv);
        @(negedge clk);
        repeat (dly) @(negedge clk);
        if (lv) low_volt = 1'b1; else arr_done = 1'b1;
        @(negedge clk);
        low_volt = 1'b0; arr_done = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int s0;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(REG_CTRL, v); check("R1 ctrl", v, 32'h0);
        rd(REG_ADDR, v); check("R1 addr", v, 32'h0);
        rd(REG_DATA, v); check("R1 data", v, 32'h0);
        check("R1 strobes", {30'h0, arr_prog, arr_erase}, 32'h0);

        // R2 write modes and width
        wr(REG_ADDR, AL_DIRECT, 32'hFFFF_FFFF); rd(REG_ADDR, v); check("R2 addr direct", v, 32'hFFF);
        wr(REG_ADDR, AL_CLEAR, 32'h0F0);        rd(REG_ADDR, v); check("R2 addr clear", v, 32'hF0F);
        wr(REG_ADDR, AL_SET, 32'h030);          rd(REG_ADDR, v); check("R2 addr set", v, 32'hF3F);
        wr(REG_ADDR, AL_NONE, 32'h0);           rd(REG_ADDR, v); check("R2 addr none", v, 32'hF3F);
        wr(REG_DATA, AL_DIRECT, 32'h1234_5678);
        wr(REG_DATA, AL_SET, 32'h8000_0000);    rd(REG_DATA, v); check("R2 data set", v, 32'h9234_5678);
        wr(REG_KEY, AL_DIRECT, 32'h55);         rd(REG_KEY, v);  check("R2 key reads 0", v, 32'h0);

        // R3 accepted program
        wr(REG_ADDR, AL_DIRECT, 32'h123);
        wr(REG_DATA, AL_DIRECT, 32'hCAFE_F00D);
        wr(REG_CTRL, AL_DIRECT, 32'h1);
        wr(REG_CTRL, AL_SET, 32'h4000);
        unlock();
        s0 = n_strobe;
        wr(REG_CTRL, AL_SET, 32'h8000);
        rd(REG_CTRL, v); check("R3 busy after start", v, cv(1, 1, 0, 0, 1));
        check("R6 prog strobe", {30'h0, arr_prog, arr_erase}, 32'h2);
        check("R3 addr out", {20'h0, arr_addr}, 32'h123);
        check("R3 data out", arr_wdata, 32'hCAFE_F00D);
        @(negedge clk);
        check("R6 strobe one cycle", {31'h0, arr_prog}, 32'h0);
        // R8 writes ignored while busy
        wr(REG_ADDR, AL_DIRECT, 32'h456);
        wr(REG_CTRL, AL_CLEAR, 32'h4000);
        rd(REG_ADDR, v); check("R8 addr held", v, 32'h123);
        rd(REG_CTRL, v); check("R8 ctrl held", v, cv(1, 1, 0, 0, 1));
        arr_done = 1'b1; @(negedge clk); arr_done = 1'b0;
        rd(REG_CTRL, v); check("R7 busy clears on done", v, cv(0, 1, 0, 0, 1));
        check("R6 single strobe count", n_strobe - s0, 1);

        // R5 armed consumed: second start without keys
        wr(REG_CTRL, AL_SET, 32'h8000);
        rd(REG_CTRL, v); check("R5 consumed arm rejects", v, cv(0, 1, 1, 0, 1));

        // R10 no-op recovery clears error
        wr(REG_CTRL, AL_CLEAR, 32'hF);
        unlock();
        s0 = n_strobe;
        wr(REG_CTRL, AL_SET, 32'h8000);
        rd(REG_CTRL, v); check("R10 nop accepted clears werr", v, cv(1, 1, 0, 0, 0));
        @(negedge clk);
        rd(REG_CTRL, v); check("R6 nop one busy cycle", v, cv(0, 1, 0, 0, 0));
        check("R6 nop no strobe", n_strobe - s0, 0);

        // R4 start without unlock
        s0 = n_strobe;
        wr(REG_CTRL, AL_DIRECT, 32'h4004);
        wr(REG_CTRL, AL_SET, 32'h8000);
        rd(REG_CTRL, v); check("R4 reject", v, cv(0, 1, 1, 0, 4));
        check("R4 no strobe", n_strobe - s0, 0);

        // R5 keys before write enable
        wr(REG_CTRL, AL_DIRECT, 32'h0004);
        unlock();
        wr(REG_CTRL, AL_SET, 32'h4000);
        wr(REG_CTRL, AL_SET, 32'h8000);
        rd(REG_CTRL, v); check("R5 keys need wren", v, cv(0, 1, 1, 0, 4));

        // R5 broken sequence
        wr(REG_KEY, AL_DIRECT, KEY_STEP0);
        wr(REG_KEY, AL_DIRECT, KEY_STEP1);
        wr(REG_KEY, AL_DIRECT, 32'h1234);
        wr(REG_KEY, AL_DIRECT, KEY_STEP2);
        wr(REG_CTRL, AL_SET, 32'h8000);
        rd(REG_CTRL, v); check("R5 broken keys", v, cv(0, 1, 1, 0, 4));

        // R5 clearing wren disarms
        unlock();
        wr(REG_CTRL, AL_CLEAR, 32'h4000);
        wr(REG_CTRL, AL_SET, 32'h4000);
        wr(REG_CTRL, AL_SET, 32'h8000);
        rd(REG_CTRL, v); check("R5 wren drop disarms", v, cv(0, 1, 1, 0, 4));

        // R9 low-voltage abort of erase, together with done
        unlock();
        wr(REG_CTRL, AL_SET, 32'h8000);
        check("R6 erase strobe", {30'h0, arr_prog, arr_erase}, 32'h1);
        @(negedge clk);
        low_volt = 1'b1; arr_done = 1'b1;
        @(negedge clk);
        low_volt = 1'b0; arr_done = 1'b0;
        rd(REG_CTRL, v); check("R9 lvd abort", v, cv(0, 1, 0, 1, 4));

        // Random rounds
        for (int it = 0; it < 60; it++) begin
            logic [3:0]  op;
            logic [31:0] a, d, k;
            int          mode, bad_step;
            logic        acc, lv;
            op   = 4'($urandom_range(0, 7));
            a    = $urandom; d = $urandom;
            mode = $urandom_range(0, 3);
            bad_step = $urandom_range(0, 2);
            acc  = (mode == 0) || (mode == 3);
            wr(REG_ADDR, AL_DIRECT, a);
            wr(REG_DATA, AL_DIRECT, d);
            wr(REG_CTRL, AL_DIRECT, {28'h0, op});
            if (mode != 2) wr(REG_CTRL, AL_SET, 32'h4000);
            for (int st = 0; st < 3; st++) begin
                k = (st == 0) ? KEY_STEP0 : (st == 1) ? KEY_STEP1 : KEY_STEP2;
                if (mode == 1 && st == bad_step) k = k ^ (32'h1 << $urandom_range(0, 31));
                wr(REG_KEY, AL_DIRECT, k);
            end
            if (mode == 2) wr(REG_CTRL, AL_SET, 32'h4000);
            s0 = n_strobe;
            wr(REG_CTRL, AL_SET, 32'h8000);
            rd(REG_CTRL, v); check(acc ? "R3 random start" : "R5 random reject", v, cv(acc, 1, !acc, 0, op));
            if (acc && (op == OP_PROG || op == OP_ERASE)) begin
                check("R6 random strobe", {30'h0, arr_prog, arr_erase},
                      {30'h0, op == OP_PROG, op == OP_ERASE});
                check("R3 random addr", {20'h0, arr_addr}, a & 32'hFFF);
                lv = 1'($urandom_range(0, 1));
                finish_op($urandom_range(0, 5), lv);
                rd(REG_CTRL, v); check(lv ? "R9 random abort" : "R7 random done", v, cv(0, 1, 0, lv, op));
            end else begin
                @(negedge clk);
                rd(REG_CTRL, v); check("R6 random idle", v, cv(0, 1, !acc, 0, op));
                check("R4 random no strobe", n_strobe - s0, 0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule